// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models a small serial EEPROM that answers a host driving chip select, serial clock and data in as plain pins. The host may bit-bang these at any rate slower than the system clock. All three inputs are sampled by the fast system clock. Only a rising edge of chip select or of the serial clock makes anything happen. The array holds 64 words of 16 bits.

After chip select rises, the block waits for a start bit of 1. It then collects a 2-bit opcode and a 6-bit address. The commands are:

| Opcode | Address bits | Command | Next state |
|---|---|---|---|
| `10` | any | read | `ST_READ` |
| `01` | any | write | `ST_WRITE` |
| `00` | `11xxxx` | enable | `ST_IDLE` |
| `00` | `00xxxx` | disable | `ST_IDLE` |
| `00` | `01xxxx` | write-all | `ST_WRALL` |

A read streams words without end. The first bit is a dummy 0, and the address advances after every 16 bits. A write waits for a new chip-select cycle once it has stored its word. Write-all goes straight back to command decoding. A test-only backdoor port can load any word and read any word at any time.

The control is a five-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Serial clock edges are ignored. |
| `ST_CMD` | Collecting the start bit and the 8 command bits. |
| `ST_READ` | Shifting data out. |
| `ST_WRITE` | Shifting in one word. |
| `ST_WRALL` | Shifting in the fill word. |

The transitions are:

| From | To | Trigger |
|---|---|---|
| any state | `ST_CMD` | Chip select rises. |
| `ST_CMD` | `ST_READ` | A read command is decoded. |
| `ST_CMD` | `ST_WRITE` | A write command is decoded while writes are enabled. |
| `ST_CMD` | `ST_WRALL` | A write-all command is decoded while writes are enabled. |
| `ST_CMD` | `ST_IDLE` | An enable, disable or unsupported command is decoded, or a write or write-all arrives while writes are locked. |
| `ST_READ` | `ST_READ` | 16 bits have been sent; the block moves to the next address. |
| `ST_WRITE` | `ST_IDLE` | 16 bits have been stored. |
| `ST_WRALL` | `ST_CMD` | 16 bits have been stored. |

Top module: `mw_eeprom`

## Requirements
- R1: After reset, do_o is 0, every word reads 0 on the backdoor, and writes are locked.
- R2: While cs is low, do_o is 0 and serial clock edges change no internal state.
- R3: A rising edge of cs puts the block in command mode with counters and shift registers cleared. Leading 0 bits before the start bit of 1 are skipped.
- R4: A read command (opcode 10) drives do_o to 0 for one bit after the last address bit. It then shifts out the addressed word MSB first, one bit per SK rising edge; do_o shows each bit from the clock after that edge.
- R5: A read keeps going past 16 bits, moving to the next address, and the address wraps from 63 to 0.
- R6: With writes enabled, a write command (opcode 01) stores the next 16 DI bits, MSB first, at its address. The block then ignores SK until cs rises again.
- R7: With writes enabled, write-all (opcode 00, address 01xxxx) loads the next 16 DI bits into every word. The block then decodes a further command without a new cs cycle.
- R8: Write and write-all change nothing unless enabled. The enable command is opcode 00 with address 11xxxx; the disable command is opcode 00 with address 00xxxx.
- R9: bd_we writes bd_wdata at bd_addr on a clock edge, and bd_rdata shows the word at bd_addr combinationally.
- R10: Shifting happens once per SK rising edge, however many system clocks SK stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data out of the block |
| bd_we | input | 1 | Backdoor write strobe (test only) |
| bd_addr | input | 6 | Backdoor word address |
| bd_wdata | input | 16 | Backdoor write data |
| bd_rdata | output | 16 | Backdoor read data |

## Verification
An SK rising edge is seen at the first system clock edge where sk is high and was low at the previous edge. do_o changes at that same clock edge. The bench therefore raises SK at a falling clock edge and samples do_o at the next falling edge, one clock later, before dropping SK. A word written serially is in the array one clock after its sixteenth SK edge. The bench reads it on the backdoor only after the chip-select cycle has closed, several clocks later. Backdoor reads are combinational, so each is sampled one falling edge after the address is driven.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_WRITE,
        ST_WRALL
    } state_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_FILL   = 2'b01;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_edge_detect.sv
module mw_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    output logic cs_rise,
    output logic sk_rise
);

    logic cs_q;
    logic sk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    always_comb begin
        cs_rise = cs & ~cs_q;
        sk_rise = sk & ~sk_q;
    end

endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic [DATA_W-1:0] bd_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (fill_en) begin
                mem[i] <= fill_data;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                mem[i] <= wr_data;
            end else if (bd_we && (bd_addr == ADDR_W'(i))) begin
                mem[i] <= bd_wdata;
            end
        end
    end

    always_comb begin
        rd_data  = mem[rd_addr];
        bd_rdata = mem[bd_addr];
    end

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cs,
    input  logic                                cs_rise,
    input  logic                                sk_rise,
    input  logic                                di,
    output logic [ADDR_W-1:0]                   rd_addr,
    input  logic [DATA_W-1:0]                   rd_data,
    output logic                                wr_en,
    output logic [ADDR_W-1:0]                   wr_addr,
    output logic [DATA_W-1:0]                   wr_data,
    output logic                                fill_en,
    output logic [DATA_W-1:0]                   fill_data,
    output logic                                dout,
    output state_t                              state_o,
    output logic [$clog2(DATA_W+1)-1:0]         tick_o,
    output logic [ADDR_W-1:0]                   addr_o,
    output logic                                en_o
);

    localparam int TICK_W   = $clog2(DATA_W + 1);
    localparam int CMD_BITS = 3 + ADDR_W;

    state_t              state_q, state_d;
    logic [TICK_W-1:0]   tick_q, tick_d;
    logic [DATA_W-2:0]   in_q, in_d;
    logic [DATA_W-1:0]   out_q, out_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic                en_q, en_d;
    logic                do_q, do_d;
    logic [DATA_W-1:0]   in_shift;
    logic [1:0]          op;
    logic [ADDR_W-1:0]   cmd_addr;
    logic                last_cmd_bit;
    logic                last_data_bit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            in_q    <= '0;
            out_q   <= '0;
            addr_q  <= '0;
            en_q    <= 1'b0;
            do_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
            in_q    <= in_d;
            out_q   <= out_d;
            addr_q  <= addr_d;
            en_q    <= en_d;
            do_q    <= do_d;
        end
    end

    always_comb begin
        in_shift      = {in_q, di};
        op            = in_shift[ADDR_W+1:ADDR_W];
        cmd_addr      = in_shift[ADDR_W-1:0];
        last_cmd_bit  = (tick_q == TICK_W'(CMD_BITS - 1));
        last_data_bit = (tick_q == TICK_W'(DATA_W - 1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        tick_d  = tick_q;
        in_d    = in_q;
        out_d   = out_q;
        addr_d  = addr_q;
        en_d    = en_q;
        do_d    = do_q;
        wr_en   = 1'b0;
        fill_en = 1'b0;

        if (cs_rise) begin
            state_d = ST_CMD;
            tick_d  = '0;
            in_d    = '0;
            out_d   = '0;
            do_d    = 1'b0;
        end else if (cs && sk_rise) begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_CMD: begin
                    if ((tick_q != '0) || di) begin
                        in_d   = in_shift[DATA_W-2:0];
                        tick_d = tick_q + TICK_W'(1);
                        if (last_cmd_bit) begin
                            tick_d = '0;
                            in_d   = '0;
                            unique case (op)
                                OP_READ: begin
                                    addr_d  = cmd_addr;
                                    out_d   = rd_data;
                                    do_d    = 1'b0;
                                    state_d = ST_READ;
                                end
                                OP_WRITE: begin
                                    addr_d  = cmd_addr;
                                    state_d = en_q ? ST_WRITE : ST_IDLE;
                                end
                                OP_EXT: begin
                                    state_d = ST_IDLE;
                                    unique case (cmd_addr[ADDR_W-1:ADDR_W-2])
                                        EXT_UNLOCK: en_d = 1'b1;
                                        EXT_LOCK:   en_d = 1'b0;
                                        EXT_FILL:   state_d = en_q ? ST_WRALL : ST_IDLE;
                                        default:    state_d = ST_IDLE;
                                    endcase
                                end
                                default: state_d = ST_IDLE;
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    do_d   = out_q[DATA_W-1];
                    out_d  = {out_q[DATA_W-2:0], 1'b0};
                    tick_d = tick_q + TICK_W'(1);
                    if (last_data_bit) begin
                        addr_d = addr_q + ADDR_W'(1);
                        out_d  = rd_data;
                        tick_d = '0;
                    end
                end
                ST_WRITE: begin
                    in_d   = in_shift[DATA_W-2:0];
                    tick_d = tick_q + TICK_W'(1);
                    if (last_data_bit) begin
                        wr_en   = 1'b1;
                        state_d = ST_IDLE;
                        tick_d  = '0;
                        in_d    = '0;
                    end
                end
                ST_WRALL: begin
                    in_d   = in_shift[DATA_W-2:0];
                    tick_d = tick_q + TICK_W'(1);
                    if (last_data_bit) begin
                        fill_en = 1'b1;
                        state_d = ST_CMD;
                        tick_d  = '0;
                        in_d    = '0;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_addr   = (state_q == ST_READ) ? (addr_q + ADDR_W'(1)) : cmd_addr;
        wr_addr   = addr_q;
        wr_data   = in_shift;
        fill_data = in_shift;
        dout      = cs & do_q;
        state_o   = state_q;
        tick_o    = tick_q;
        addr_o    = addr_q;
        en_o      = en_q;
    end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    output logic              do_o,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic [DATA_W-1:0] bd_rdata
);

    localparam int TICK_W = $clog2(DATA_W + 1);

    logic              cs_rise;
    logic              sk_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              fill_en;
    logic [DATA_W-1:0] fill_data;
    state_t            ctl_state;
    logic [TICK_W-1:0] ctl_tick;
    logic [ADDR_W-1:0] ctl_addr;
    logic              ctl_en;

    mw_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .cs_rise (cs_rise),
        .sk_rise (sk_rise)
    );

    mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .cs_rise   (cs_rise),
        .sk_rise   (sk_rise),
        .di        (di),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .dout      (do_o),
        .state_o   (ctl_state),
        .tick_o    (ctl_tick),
        .addr_o    (ctl_addr),
        .en_o      (ctl_en)
    );

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .bd_we     (bd_we),
        .bd_addr   (bd_addr),
        .bd_wdata  (bd_wdata),
        .bd_rdata  (bd_rdata)
    );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cs,
    input logic                        do_o,
    input state_t                      state,
    input logic [$clog2(DATA_W+1)-1:0] tick,
    input logic [ADDR_W-1:0]           addr,
    input logic                        en
);

    p_sk_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs) |=> ($stable(tick) && $stable(addr) && $stable(en)));

    p_cs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |=> (state == ST_CMD && tick == '0));

    p_dummy_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_READ) |-> (do_o == 1'b0));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) == ST_READ && tick == '0 && $past(tick) != '0)
        |-> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

    p_write_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WRITE && state != ST_WRITE) |-> (state == ST_IDLE || state == ST_CMD));

    p_fill_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WRALL && state != ST_WRALL) |-> (state == ST_CMD));

    p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (state != ST_WRITE && state != ST_WRALL));

endmodule

bind mw_eeprom mw_eeprom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .do_o  (do_o),
    .state (ctl_state),
    .tick  (ctl_tick),
    .addr  (ctl_addr),
    .en    (ctl_en)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 8;

    // {address, data}: written serially, then read back serially and on the backdoor
    localparam logic [ADDR_W+DATA_W-1:0] VEC [NVEC] = '{
        {6'd0,  16'h0001},
        {6'd1,  16'h8000},
        {6'd2,  16'hFFFF},
        {6'd3,  16'h5555},
        {6'd17, 16'hAAAA},
        {6'd31, 16'h1234},
        {6'd48, 16'hC3A5},
        {6'd63, 16'h7FFE}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs = 1'b0;
    logic              sk = 1'b0;
    logic              di = 1'b0;
    logic              do_o;
    logic              bd_we = 1'b0;
    logic [ADDR_W-1:0] bd_addr = '0;
    logic [DATA_W-1:0] bd_wdata = '0;
    logic [DATA_W-1:0] bd_rdata;

    int checks = 0;
    int errors = 0;
    int hold   = 1;
    logic [DATA_W-1:0] mdl [DEPTH];

    always #5 clk = ~clk;

    mw_eeprom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sk       (sk),
        .di       (di),
        .do_o     (do_o),
        .bd_we    (bd_we),
        .bd_addr  (bd_addr),
        .bd_wdata (bd_wdata),
        .bd_rdata (bd_rdata)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic q);
        di = b;
        sk = 1'b1;
        repeat (hold) @(negedge clk);
        q = do_o;
        sk = 1'b0;
        idle(2);
    endtask

    task automatic cs_start;
        cs = 1'b0;
        idle(2);
        cs = 1'b1;
        idle(2);
    endtask

    task automatic cs_stop;
        cs = 1'b0;
        idle(3);
    endtask

    task automatic send_frame(input logic [1:0] op, input logic [ADDR_W-1:0] a, output logic last_q);
        logic q;
        clk_bit(1'b1, q);
        clk_bit(op[1], q);
        clk_bit(op[0], q);
        for (int i = ADDR_W - 1; i >= 0; i--) clk_bit(a[i], q);
        last_q = q;
    endtask

    task automatic shift_word(input logic [DATA_W-1:0] w, output logic [DATA_W-1:0] r);
        logic q;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            clk_bit(w[i], q);
            r[i] = q;
        end
    endtask

    task automatic bd_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bd_addr  = a;
        bd_wdata = d;
        bd_we    = 1'b1;
        idle(1);
        bd_we    = 1'b0;
        mdl[a]   = d;
        idle(1);
    endtask

    task automatic bd_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bd_addr = a;
        idle(1);
        d = bd_rdata;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input int n);
        logic dmy;
        logic [DATA_W-1:0] r;
        cs_start();
        send_frame(2'b10, a, dmy);
        chk({req, " dummy bit"}, {15'd0, dmy}, 16'h0000);
        for (int k = 0; k < n; k++) begin
            shift_word('0, r);
            chk(req, r, mdl[ADDR_W'(a + k)]);
        end
        cs_stop();
    endtask

    task automatic ext_cmd(input logic [1:0] code);
        logic dmy;
        cs_start();
        send_frame(2'b00, {code, 4'b0000}, dmy);
        cs_stop();
    endtask

    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic dmy;
        logic [DATA_W-1:0] r;
        cs_start();
        send_frame(2'b01, a, dmy);
        shift_word(d, r);
        cs_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] r;
        logic dmy;
        logic q;
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk("R1 do_o after reset", {15'd0, do_o}, 16'h0000);
        bd_read(6'd0, r);
        chk("R1 word 0 after reset", r, 16'h0000);
        bd_read(6'd63, r);
        chk("R1 word 63 after reset", r, 16'h0000);

        // R1/R8: write before enable is ignored
        write_word(6'd5, 16'h1234);
        bd_read(6'd5, r);
        chk("R8 locked write", r, 16'h0000);

        // table walk: R6 write, R4 read, R9 backdoor view
        ext_cmd(2'b11);
        for (int v = 0; v < NVEC; v++) begin
            write_word(VEC[v][ADDR_W+DATA_W-1:DATA_W], VEC[v][DATA_W-1:0]);
            mdl[VEC[v][ADDR_W+DATA_W-1:DATA_W]] = VEC[v][DATA_W-1:0];
            read_check("R4 read after write", VEC[v][ADDR_W+DATA_W-1:DATA_W], 1);
            bd_read(VEC[v][ADDR_W+DATA_W-1:DATA_W], r);
            chk("R9 backdoor after serial write", r, VEC[v][DATA_W-1:0]);
        end

        // R9 backdoor load, R5 streaming with wrap 63 -> 0
        bd_write(6'd61, 16'h0F0F);
        bd_write(6'd62, 16'hF00F);
        bd_write(6'd63, 16'h8001);
        bd_write(6'd0,  16'h1357);
        bd_write(6'd1,  16'h2468);
        read_check("R5 stream wrap", 6'd61, 5);

        // R6: after a write, a second frame in the same cs cycle does nothing
        bd_write(6'd20, 16'hFFFF);
        cs_start();
        send_frame(2'b01, 6'd7, dmy);
        shift_word(16'hBEEF, r);
        mdl[7] = 16'hBEEF;
        send_frame(2'b10, 6'd20, dmy);
        shift_word('0, r);
        chk("R6 idle after write", r, 16'h0000);
        cs_stop();
        bd_read(6'd7, r);
        chk("R6 stored word", r, 16'hBEEF);

        // R7: write-all, then a read decoded without a new cs cycle
        cs_start();
        send_frame(2'b00, 6'b010000, dmy);
        shift_word(16'h5A3C, r);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h5A3C;
        send_frame(2'b10, 6'd10, dmy);
        chk("R7 dummy after fill", {15'd0, dmy}, 16'h0000);
        shift_word('0, r);
        chk("R7 read after fill", r, 16'h5A3C);
        cs_stop();
        bd_read(6'd0, r);
        chk("R7 fill word 0", r, 16'h5A3C);
        bd_read(6'd63, r);
        chk("R7 fill word 63", r, 16'h5A3C);

        // R8: disable locks writes again
        ext_cmd(2'b00);
        write_word(6'd33, 16'h1111);
        bd_read(6'd33, r);
        chk("R8 write after disable", r, 16'h5A3C);
        cs_start();
        send_frame(2'b00, 6'b010000, dmy);
        shift_word(16'h0000, r);
        cs_stop();
        bd_read(6'd12, r);
        chk("R8 fill after disable", r, 16'h5A3C);

        // R2: dropping cs forces do_o low, SK is ignored
        bd_write(6'd40, 16'hFFFF);
        cs_start();
        send_frame(2'b10, 6'd40, dmy);
        clk_bit(1'b0, q);
        chk("R2 data bit before cs drop", {15'd0, q}, 16'h0001);
        cs = 1'b0;
        idle(2);
        chk("R2 do_o with cs low", {15'd0, do_o}, 16'h0000);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, q);
        chk("R2 do_o with cs low and SK", {15'd0, do_o}, 16'h0000);
        idle(2);

        // R3: leading zeros before the start bit are skipped
        cs_start();
        clk_bit(1'b0, q);
        clk_bit(1'b0, q);
        clk_bit(1'b0, q);
        send_frame(2'b10, 6'd40, dmy);
        shift_word('0, r);
        chk("R3 read after leading zeros", r, 16'hFFFF);
        cs_stop();

        // R10: long SK high phases still shift once each
        hold = 6;
        read_check("R10 long SK pulses", 6'd62, 2);
        hold = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule